// File: doc/BRIEF.md
# Pulse-Interval Forward-Link Symbol Decoder

This block turns the reader-to-tag pulse-interval-encoded envelope into data bits. A one-bit envelope input is sampled on every clock. The input is high during the high part of a symbol and low during the pulse at its end. The decoder measures each symbol as the number of samples from one falling edge of the envelope to the next.

The preamble is used for calibration. It is a delimiter low, then a data-0 symbol that is discarded, then the receive calibration symbol, then, when selected, the return-link calibration symbol. The receive calibration count is kept, and half of it, rounded down, becomes the decision pivot. Each data symbol after the preamble is compared with the pivot and produces a bit with a one-cycle strobe.

Both calibration counts are available at the outputs, so the transmit side can derive its return-link timing. A frame-start pulse marks the end of the preamble. Malformed input raises an error pulse and sends the decoder back to searching for a delimiter. A long high interval during data ends the frame quietly.

Top module: `pie_fwd_decoder`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, `bit_o`, `bit_vld_o`, `frame_start_o` and `err_o` are 0 and `rtcal_o` and `trcal_o` are 0.
- R2: A symbol's length is the number of samples between consecutive falling edges of the registered envelope. In a frame, the first falling edge opens the delimiter. The symbol closed by the second falling edge is treated as data-0 and produces no bit.
- R3: The length of the next symbol is stored on `rtcal_o`. The pivot becomes that length shifted right by one bit, so an odd count rounds down.
- R4: After the preamble, every data symbol gives one bit. A length at or below the pivot gives `bit_o`=0, and a length above the pivot gives `bit_o`=1.
- R5: When `trcal_en_i` is 1 as the receive calibration symbol closes, the following symbol's length is stored on `trcal_o` and is not decoded as data. When `trcal_en_i` is 0, `trcal_o` keeps its earlier value and the next symbol is data.
- R6: `frame_start_o` pulses for exactly one cycle per frame, once the last calibration symbol has been stored.
- R7: Outside the search state, a low interval shorter than `MIN_PW` samples pulses `err_o` for one cycle and returns the decoder to searching.
- R8: During the preamble, a symbol count that reaches the counter's maximum value `2**CNT_W-1` pulses `err_o` and returns the decoder to searching.
- R9: During data, a count that reaches the maximum value ends the frame with no error and no bit.
- R10: `bit_vld_o` and `err_o` are never high in the same cycle. The calibration outputs do not change in any cycle where `bit_vld_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the envelope is sampled once per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| env_i | input | 1 | Demodulated envelope, high = carrier present |
| trcal_en_i | input | 1 | 1 when the preamble carries a return-link calibration symbol |
| bit_o | output | 1 | Decoded data bit |
| bit_vld_o | output | 1 | One-cycle strobe qualifying `bit_o` |
| frame_start_o | output | 1 | One-cycle pulse when calibration completes |
| err_o | output | 1 | One-cycle pulse on a short low or a preamble overflow |
| rtcal_o | output | CNT_W | Stored receive calibration length in samples |
| trcal_o | output | CNT_W | Stored return-link calibration length in samples |

## Verification
A wrong pivot or a mis-stored calibration count shows up as a flipped bit on the first data symbol whose length lies next to the pivot. For that reason the frames place symbols exactly at the pivot and one sample above it, using both even and odd calibration counts. A sequencer that skips or repeats a preamble step shows up in the frame that follows. It appears as a missing or extra bit, a wrong value on `trcal_o`, or a missing frame-start pulse. A broken error path is caught by a frame with a short delimiter and by a frame that stalls in the preamble. Either case should give exactly one error pulse and no bits.

// File: rtl/pie_pkg.sv
package pie_pkg;
  typedef enum logic [2:0] {
    ST_SEARCH = 3'd0,
    ST_LEAD   = 3'd1,
    ST_RXCAL  = 3'd2,
    ST_TXCAL  = 3'd3,
    ST_DATA   = 3'd4
  } dec_state_t;
endpackage

// File: rtl/pie_env_sampler.sv
module pie_env_sampler (
  input  logic clk,
  input  logic rst,
  input  logic env_i,
  output logic env_q,
  output logic fall,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      env_q  <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      env_q  <= env_i;
      prev_q <= env_q;
    end
  end

  assign fall = prev_q & ~env_q;
  assign rise = ~prev_q & env_q;
endmodule

// File: rtl/pie_run_counter.sv
module pie_run_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         sat
);
  localparam logic [W-1:0] CMAX = {W{1'b1}};

  assign sat = (cnt == CMAX);

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (clr)          cnt <= W'(1);
    else if (inc && !sat)  cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/pie_fwd_decoder.sv
module pie_fwd_decoder #(
  parameter int CNT_W  = 8,
  parameter int MIN_PW = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             env_i,
  input  logic             trcal_en_i,
  output logic             bit_o,
  output logic             bit_vld_o,
  output logic             frame_start_o,
  output logic             err_o,
  output logic [CNT_W-1:0] rtcal_o,
  output logic [CNT_W-1:0] trcal_o
);
  import pie_pkg::*;

  localparam logic [CNT_W-1:0] MIN_LOW = CNT_W'(MIN_PW);

  logic             env_q, fall, rise;
  logic [CNT_W-1:0] sym_len, low_len;
  logic             sym_sat, low_sat;
  logic [CNT_W-1:0] pivot_q;
  dec_state_t       state_q;

  pie_env_sampler u_smp (
    .clk(clk), .rst(rst), .env_i(env_i),
    .env_q(env_q), .fall(fall), .rise(rise)
  );

  pie_run_counter #(.W(CNT_W)) u_sym (
    .clk(clk), .rst(rst), .clr(fall), .inc(1'b1),
    .cnt(sym_len), .sat(sym_sat)
  );

  pie_run_counter #(.W(CNT_W)) u_low (
    .clk(clk), .rst(rst), .clr(fall), .inc(~env_q),
    .cnt(low_len), .sat(low_sat)
  );

  logic short_low;
  assign short_low = rise && (low_len < MIN_LOW) && !low_sat;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_SEARCH;
      pivot_q       <= '0;
      rtcal_o       <= '0;
      trcal_o       <= '0;
      bit_o         <= 1'b0;
      bit_vld_o     <= 1'b0;
      frame_start_o <= 1'b0;
      err_o         <= 1'b0;
    end else begin
      bit_vld_o     <= 1'b0;
      frame_start_o <= 1'b0;
      err_o         <= 1'b0;
      if (state_q == ST_SEARCH) begin
        if (fall) state_q <= ST_LEAD;
      end else if (short_low) begin
        err_o   <= 1'b1;
        state_q <= ST_SEARCH;
      end else if (sym_sat) begin
        if (state_q != ST_DATA) err_o <= 1'b1;
        state_q <= ST_SEARCH;
      end else if (fall) begin
        unique case (state_q)
          ST_LEAD:  state_q <= ST_RXCAL;
          ST_RXCAL: begin
            rtcal_o <= sym_len;
            pivot_q <= sym_len >> 1;
            if (trcal_en_i) begin
              state_q <= ST_TXCAL;
            end else begin
              state_q       <= ST_DATA;
              frame_start_o <= 1'b1;
            end
          end
          ST_TXCAL: begin
            trcal_o       <= sym_len;
            state_q       <= ST_DATA;
            frame_start_o <= 1'b1;
          end
          ST_DATA: begin
            bit_o     <= (sym_len > pivot_q);
            bit_vld_o <= 1'b1;
          end
          default: state_q <= ST_SEARCH;
        endcase
      end
    end
  end
endmodule

// File: rtl/pie_fwd_decoder_chk.sv
module pie_fwd_decoder_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             bit_vld_o,
  input logic             err_o,
  input logic             frame_start_o,
  input logic [CNT_W-1:0] rtcal_o,
  input logic [CNT_W-1:0] trcal_o,
  input logic [CNT_W-1:0] pivot_q,
  input pie_pkg::dec_state_t state_q
);
  // R10: a bit strobe and an error pulse never coincide
  assert_no_bit_with_err_R10: assert property (@(posedge clk) disable iff (rst)
    !(bit_vld_o && err_o));

  // R10: calibration outputs stay put while bits are produced
  assert_cal_stable_R10: assert property (@(posedge clk) disable iff (rst)
    bit_vld_o |-> ($stable(rtcal_o) && $stable(trcal_o)));

  // R6: frame start lasts one cycle
  assert_frame_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    frame_start_o |=> !frame_start_o);

  // R7 / R8: an error leaves the decoder searching
  assert_err_to_search_R8: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (state_q == pie_pkg::ST_SEARCH));

  // R3: pivot agrees with the stored calibration count when the frame starts
  assert_pivot_half_R3: assert property (@(posedge clk) disable iff (rst)
    frame_start_o |-> (pivot_q == (rtcal_o >> 1)));
endmodule

bind pie_fwd_decoder pie_fwd_decoder_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .bit_vld_o(bit_vld_o), .err_o(err_o),
  .frame_start_o(frame_start_o), .rtcal_o(rtcal_o), .trcal_o(trcal_o),
  .pivot_q(pivot_q), .state_q(state_q)
);

// File: tb/pie_fwd_decoder_bench.sv
module pie_fwd_decoder_bench;
  localparam int CNT_W = 8;
  localparam int PW    = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic env_i = 1'b1;
  logic trcal_en_i = 1'b0;
  logic bit_o, bit_vld_o, frame_start_o, err_o;
  logic [CNT_W-1:0] rtcal_o, trcal_o;

  int checks = 0;
  int failures = 0;
  int err_seen = 0;
  int fs_seen = 0;
  int bits_seen = 0;
  int last_tr = 0;
  bit done = 1'b0;

  bit exp_bits[$];
  int exp_rt[$];
  int exp_tr[$];

  always #10 clk = ~clk;

  pie_fwd_decoder #(.CNT_W(CNT_W), .MIN_PW(2)) u_pie_fwd_decoder (
    .clk(clk), .rst(rst), .env_i(env_i), .trcal_en_i(trcal_en_i),
    .bit_o(bit_o), .bit_vld_o(bit_vld_o), .frame_start_o(frame_start_o),
    .err_o(err_o), .rtcal_o(rtcal_o), .trcal_o(trcal_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard as results appear
  always @(negedge clk) begin
    if (!rst) begin
      if (bit_vld_o) begin
        bits_seen++;
        if (exp_bits.size() == 0) check("R2 unexpected bit", 1, 0);
        else check("R4 bit value", int'(bit_o), int'(exp_bits.pop_front()));
      end
      if (frame_start_o) begin
        fs_seen++;
        if (exp_rt.size() == 0) check("R6 unexpected frame start", 1, 0);
        else begin
          check("R3 rtcal count", int'(rtcal_o), exp_rt.pop_front());
          check("R5 trcal count", int'(trcal_o), exp_tr.pop_front());
        end
      end
      if (err_o) err_seen++;
    end
  end

  task automatic level(input logic v, input int n);
    env_i = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic sym(input int len);
    level(1'b1, len - PW);
    level(1'b0, PW);
  endtask

  task automatic send_frame(input int rt, input int tr, input bit use_tr,
                            input int lens[$]);
    int e0, f0, b0;
    e0 = err_seen; f0 = fs_seen; b0 = bits_seen;
    foreach (lens[i]) exp_bits.push_back(lens[i] > (rt / 2));
    exp_rt.push_back(rt);
    if (use_tr) last_tr = tr;
    exp_tr.push_back(last_tr);
    trcal_en_i = use_tr;
    level(1'b0, 8);          // delimiter
    sym(10);                 // lead data-0, discarded
    sym(rt);
    if (use_tr) sym(tr);
    foreach (lens[i]) sym(lens[i]);
    level(1'b1, 300);        // idle: counter saturates in data
    check("R2 bit count", bits_seen - b0, lens.size());
    check("R6 one frame start", fs_seen - f0, 1);
    check("R9 no error at frame end", err_seen - e0, 0);
    check("R4 scoreboard drained", exp_bits.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 bit_vld in reset", int'(bit_vld_o), 0);
    check("R1 err in reset", int'(err_o), 0);
    check("R1 frame_start in reset", int'(frame_start_o), 0);
    check("R1 rtcal in reset", int'(rtcal_o), 0);
    check("R1 trcal in reset", int'(trcal_o), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 bit after reset", int'(bit_o), 0);
    level(1'b1, 5);

    // even calibration, pivot 10: boundary at 10/11, with TRcal
    send_frame(20, 35, 1'b1, '{10, 11, 6, 20, 4, 12});
    // odd calibration 21, pivot 10, no TRcal: trcal_o keeps 35
    send_frame(21, 0, 1'b0, '{10, 11, 9, 30});
    // longer calibration 40, pivot 20
    send_frame(40, 77, 1'b1, '{20, 21, 5, 60, 19});

    // R7: single-sample delimiter low
    begin
      int e0, b0;
      e0 = err_seen; b0 = bits_seen;
      level(1'b0, 1);
      level(1'b1, 300);
      check("R7 short low error", err_seen - e0, 1);
      check("R7 no bits", bits_seen - b0, 0);
    end
    // R8: stall inside the preamble
    begin
      int e0, f0;
      e0 = err_seen; f0 = fs_seen;
      level(1'b0, 5);
      level(1'b1, 300);
      check("R8 overflow error", err_seen - e0, 1);
      check("R8 no frame start", fs_seen - f0, 0);
    end
    // decoder recovers after errors
    send_frame(24, 50, 1'b1, '{12, 13});

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule